// File: doc/BRIEF.md
# ATM HEC Cell Delineation Engine

This block locates ATM cell boundaries in a byte-wide receive stream. Each byte comes with a qualifying strobe. The block looks for five-byte groups whose last byte is the header error check of the four bytes before it. A three-state machine (HUNT, PRESYNC, SYNC) settles on a boundary: it locks, confirms the lock over several cells, and then holds it while tolerating a limited number of bad headers. The confirmation threshold DELTA and the loss threshold ALPHA are parameters.

The block drives four things:
- a pulse at each cell header it finds or checks;
- a 3-bit status word: a loss-of-cell-delineation (LCD) defect flag plus an encoded delineation state;
- pulses that mark correctable and uncorrectable header errors while in SYNC;
- a 4-bit interrupt status register with an active-low interrupt line. The host clears the register by pulsing a read strobe.

Top module: `atm_cell_delin`

## Requirements
- R1: While reset is asserted and right after it: `stat` = 3'b101 (HUNT code, LCD set), `irq_stat` = 0 and `irq_n` = 1.
- R2: In HUNT the check moves one byte per accepted byte. A header is valid when the fifth byte equals 0x55 XOR the CRC-8 of the previous four bytes. The CRC uses generator x^8+x^2+x+1, MSB first, zero initial value. A valid header moves the block to PRESYNC. No lock happens before five bytes have been accepted since reset.
- R3: Only bytes with `in_valid` high are counted. In PRESYNC and SYNC a header is checked only every CELL_LEN (53) accepted bytes. `hdr_mark` pulses exactly once for each such check and once on each lock in HUNT.
- R4: In PRESYNC, a single invalid header returns the block to HUNT.
- R5: DELTA (6) consecutive valid headers checked in PRESYNC move the block to SYNC. The header that caused the lock does not count toward DELTA.
- R6: In SYNC, ALPHA (7) consecutive errored headers return the block to HUNT. Both single-bit and multi-bit errors count. A valid header resets the run, so ALPHA-1 errors followed by a good header keep SYNC.
- R7: In SYNC, a header whose syndrome is a single-bit error is correctable when the header before it was error-free. This pulses `hec_corr` and sets `irq_stat[3]`. Any other header error pulses `hec_uncorr` and sets `irq_stat[2]`.
- R8: `stat[2:1]` encodes the state: 2'b10 for HUNT, 2'b01 for PRESYNC, 2'b00 for SYNC. `stat[0]` is the LCD defect. It is cleared on entering SYNC and set on leaving it.
- R9: Entering SYNC sets `irq_stat[1]`. Leaving SYNC sets `irq_stat[0]`.
- R10: A cycle with `irq_rd` high clears `irq_stat`, but an event in that same cycle still sets its bit. `irq_n` is low exactly when any `irq_stat` bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Qualifies `in_byte` |
| in_byte | input | 8 | Receive stream byte |
| irq_rd | input | 1 | Host read strobe; clears the interrupt status |
| hdr_mark | output | 1 | Pulse per header found or checked |
| stat | output | 3 | {state code[1:0], LCD defect} |
| hec_corr | output | 1 | Correctable header error pulse (SYNC) |
| hec_uncorr | output | 1 | Uncorrectable header error pulse (SYNC) |
| irq_stat | output | 4 | {corr, uncorr, LCD cleared, LCD declared} |
| irq_n | output | 1 | Active-low interrupt |

## Verification
The bench targets the following corner cases:
- **Consecutive single-bit errors.** A second single-bit error right after a first one must count as uncorrectable. A design that tracks the history wrongly would report it as correctable.
- **Loss-threshold boundary.** The bench sends exactly ALPHA-1 errored headers, then a good one. An off-by-one counter would drop sync too early or too late.
- **Confirmation counting.** A design that counted the locking header toward DELTA would reach SYNC one cell early.
- **Invalid-strobe bytes.** Bytes driven while `in_valid` is low would complete a valid header if they were accepted. A design that sampled them would lock early.
- **Fresh-reset lock.** After reset, a lone 0x55 byte together with the cleared window would look like a valid header. A design without the fill guard would lock on it.

// File: rtl/atm_delin_pkg.sv
package atm_delin_pkg;

  typedef enum logic [1:0] {
    ST_HUNT    = 2'd0,
    ST_PRESYNC = 2'd1,
    ST_SYNC    = 2'd2
  } dl_state_e;

  // One step of multiplication by x modulo x^8+x^2+x+1
  function automatic logic [7:0] crc_mulx(input logic [7:0] s);
    return {s[6:0], 1'b0} ^ (s[7] ? 8'h07 : 8'h00);
  endfunction

  // Remainder of hdr(x)*x^8 modulo the generator, MSB first, zero start
  function automatic logic [7:0] hec_crc8(input logic [31:0] hdr);
    logic [7:0] r;
    r = '0;
    for (int i = 31; i >= 0; i--) begin
      if (r[7] ^ hdr[i]) r = {r[6:0], 1'b0} ^ 8'h07;
      else               r = {r[6:0], 1'b0};
    end
    return r;
  endfunction

  // True when syn equals x^d mod g for some codeword bit d in 0..39
  function automatic logic single_bit_syn(input logic [7:0] syn);
    logic [7:0] s;
    logic       hit;
    s   = 8'h01;
    hit = 1'b0;
    for (int d = 0; d < 40; d++) begin
      if (s == syn) hit = 1'b1;
      s = crc_mulx(s);
    end
    return hit;
  endfunction

  // Status field encoding of the delineation state
  function automatic logic [1:0] state_code(input dl_state_e s);
    case (s)
      ST_HUNT:    return 2'b10;
      ST_PRESYNC: return 2'b01;
      default:    return 2'b00;
    endcase
  endfunction

endpackage

// File: rtl/delin_hdr_window.sv
module delin_hdr_window
  import atm_delin_pkg::*;
#(
  parameter logic [7:0] COSET = 8'h55
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       in_valid,
  input  logic [7:0] in_byte,
  output logic       win_new,
  output logic       win_full,
  output logic [7:0] syndrome
);

  localparam int HDR_LEN = 5;
  localparam int FW = $clog2(HDR_LEN + 1);
  localparam logic [FW-1:0] FILL_MAX = FW'(HDR_LEN);

  // win_q[0] is the newest byte, win_q[HDR_LEN-1] the oldest
  logic [7:0]    win_q [HDR_LEN];
  logic [FW-1:0] fill_q;
  logic [7:0]    hec_calc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_q[0] <= '0;
      win_new  <= 1'b0;
      fill_q   <= '0;
    end else begin
      win_new <= in_valid;
      if (in_valid) begin
        win_q[0] <= in_byte;
        if (fill_q != FILL_MAX) fill_q <= fill_q + 1'b1;
      end
    end
  end

  for (genvar g = 1; g < HDR_LEN; g++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        win_q[g] <= '0;
      else if (in_valid) win_q[g] <= win_q[g-1];
    end
  end

  assign win_full = (fill_q == FILL_MAX);
  assign hec_calc = hec_crc8({win_q[4], win_q[3], win_q[2], win_q[1]}) ^ COSET;
  assign syndrome = hec_calc ^ win_q[0];

  // R3
  byte_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    win_new |-> $past(in_valid));

  // R2
  fill_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (win_full && !in_valid) |=> win_full);

endmodule

// File: rtl/delin_fsm.sv
module delin_fsm
  import atm_delin_pkg::*;
#(
  parameter int ALPHA    = 7,
  parameter int DELTA    = 6,
  parameter int CELL_LEN = 53
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       win_new,
  input  logic       win_full,
  input  logic [7:0] syndrome,
  output dl_state_e  state_o,
  output logic       hdr_mark,
  output logic       hec_corr,
  output logic       hec_uncorr,
  output logic       sync_enter,
  output logic       sync_leave
);

  localparam int HDR_LEN = 5;
  localparam int PW = $clog2(CELL_LEN);
  localparam int GW = (DELTA > 1) ? $clog2(DELTA) : 1;
  localparam int BW = (ALPHA > 1) ? $clog2(ALPHA) : 1;
  localparam logic [PW-1:0] POS_LAST = PW'(CELL_LEN - 1);
  localparam logic [PW-1:0] POS_PRE  = PW'(HDR_LEN - 2);
  localparam logic [PW-1:0] POS_HDR  = PW'(HDR_LEN - 1);
  localparam logic [GW-1:0] GOOD_LAST = GW'(DELTA - 1);
  localparam logic [BW-1:0] BAD_LAST  = BW'(ALPHA - 1);

  dl_state_e     state_q;
  logic [PW-1:0] pos_q;
  logic [GW-1:0] good_q;
  logic [BW-1:0] bad_q;
  logic          prev_clean_q;

  // Named internal events
  logic hdr_ok, single_err, chk_slot, hunt_hit;

  assign hdr_ok     = (syndrome == 8'h00);
  assign single_err = single_bit_syn(syndrome);
  assign chk_slot   = win_new && (state_q != ST_HUNT) && (pos_q == POS_PRE);
  assign hunt_hit   = win_new && (state_q == ST_HUNT) && win_full && hdr_ok;

  // Position of the newest accepted byte inside the cell
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q <= '0;
    end else if (win_new) begin
      if (state_q == ST_HUNT)    pos_q <= POS_HDR;
      else if (pos_q == POS_LAST) pos_q <= '0;
      else                        pos_q <= pos_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q      <= ST_HUNT;
      good_q       <= '0;
      bad_q        <= '0;
      prev_clean_q <= 1'b0;
      hdr_mark     <= 1'b0;
      hec_corr     <= 1'b0;
      hec_uncorr   <= 1'b0;
      sync_enter   <= 1'b0;
      sync_leave   <= 1'b0;
    end else begin
      hdr_mark   <= 1'b0;
      hec_corr   <= 1'b0;
      hec_uncorr <= 1'b0;
      sync_enter <= 1'b0;
      sync_leave <= 1'b0;
      case (state_q)
        ST_HUNT: begin
          if (hunt_hit) begin
            state_q  <= ST_PRESYNC;
            good_q   <= '0;
            hdr_mark <= 1'b1;
          end
        end
        ST_PRESYNC: begin
          if (chk_slot) begin
            hdr_mark <= 1'b1;
            if (!hdr_ok) begin
              state_q <= ST_HUNT;
            end else if (good_q == GOOD_LAST) begin
              state_q      <= ST_SYNC;
              sync_enter   <= 1'b1;
              bad_q        <= '0;
              prev_clean_q <= 1'b1;
            end else begin
              good_q <= good_q + 1'b1;
            end
          end
        end
        default: begin
          if (chk_slot) begin
            hdr_mark <= 1'b1;
            if (hdr_ok) begin
              bad_q        <= '0;
              prev_clean_q <= 1'b1;
            end else begin
              prev_clean_q <= 1'b0;
              if (single_err && prev_clean_q) hec_corr   <= 1'b1;
              else                            hec_uncorr <= 1'b1;
              if (bad_q == BAD_LAST) begin
                state_q    <= ST_HUNT;
                sync_leave <= 1'b1;
              end else begin
                bad_q <= bad_q + 1'b1;
              end
            end
          end
        end
      endcase
    end
  end

  assign state_o = state_q;

  // R4
  presync_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_PRESYNC && chk_slot && !hdr_ok) |=> (state_q == ST_HUNT));

  // R6
  sync_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_SYNC && chk_slot && hdr_ok) |=> (state_q == ST_SYNC));

  // R7
  hec_flag_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({hec_corr, hec_uncorr}));

  // R3
  slot_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != ST_HUNT && !chk_slot) |=> $stable(state_q));

  // R5
  sync_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_SYNC && $past(state_q) != ST_SYNC) |-> ($past(state_q) == ST_PRESYNC));

endmodule

// File: rtl/delin_status.sv
module delin_status
  import atm_delin_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  dl_state_e  state,
  input  logic       sync_enter,
  input  logic       sync_leave,
  input  logic       hec_corr,
  input  logic       hec_uncorr,
  input  logic       irq_rd,
  output logic [2:0] stat,
  output logic [3:0] irq_stat,
  output logic       irq_n
);

  logic       lcd_q;
  logic [3:0] irq_q;
  logic [3:0] irq_ev;

  // bit0 LCD declared, bit1 LCD cleared, bit2 uncorrectable, bit3 correctable
  assign irq_ev = {hec_corr, hec_uncorr, sync_enter, sync_leave};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lcd_q <= 1'b1;
      irq_q <= '0;
    end else begin
      if (sync_leave)      lcd_q <= 1'b1;
      else if (sync_enter) lcd_q <= 1'b0;
      irq_q <= (irq_rd ? 4'b0000 : irq_q) | irq_ev;
    end
  end

  assign stat     = {state_code(state), lcd_q};
  assign irq_stat = irq_q;
  assign irq_n    = ~|irq_q;

  // R9
  clr_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sync_enter |=> irq_stat[1]);

  // R10
  irq_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_stat != 4'b0000 && !irq_rd) |=> (irq_stat != 4'b0000));

  // R8
  lcd_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sync_enter |=> !stat[0]);

endmodule

// File: rtl/atm_cell_delin.sv
module atm_cell_delin
  import atm_delin_pkg::*;
#(
  parameter int         ALPHA    = 7,
  parameter int         DELTA    = 6,
  parameter int         CELL_LEN = 53,
  parameter logic [7:0] COSET    = 8'h55
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       in_valid,
  input  logic [7:0] in_byte,
  input  logic       irq_rd,
  output logic       hdr_mark,
  output logic [2:0] stat,
  output logic       hec_corr,
  output logic       hec_uncorr,
  output logic [3:0] irq_stat,
  output logic       irq_n
);

  logic       win_new, win_full;
  logic [7:0] syndrome;
  dl_state_e  state;
  logic       sync_enter, sync_leave;

  delin_hdr_window #(.COSET(COSET)) u_win (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_byte  (in_byte),
    .win_new  (win_new),
    .win_full (win_full),
    .syndrome (syndrome)
  );

  delin_fsm #(.ALPHA(ALPHA), .DELTA(DELTA), .CELL_LEN(CELL_LEN)) u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .win_new    (win_new),
    .win_full   (win_full),
    .syndrome   (syndrome),
    .state_o    (state),
    .hdr_mark   (hdr_mark),
    .hec_corr   (hec_corr),
    .hec_uncorr (hec_uncorr),
    .sync_enter (sync_enter),
    .sync_leave (sync_leave)
  );

  delin_status u_stat (
    .clk        (clk),
    .rst_n      (rst_n),
    .state      (state),
    .sync_enter (sync_enter),
    .sync_leave (sync_leave),
    .hec_corr   (hec_corr),
    .hec_uncorr (hec_uncorr),
    .irq_rd     (irq_rd),
    .stat       (stat),
    .irq_stat   (irq_stat),
    .irq_n      (irq_n)
  );

  // R6
  leave_to_hunt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sync_leave |-> (stat[2:1] == 2'b10));

endmodule

// File: tb/atm_cell_delin_test.sv
module atm_cell_delin_test;

  logic       clk = 1'b0;
  logic       rst_n, in_valid, irq_rd;
  logic [7:0] in_byte;
  logic       hdr_mark, hec_corr, hec_uncorr, irq_n;
  logic [2:0] stat;
  logic [3:0] irq_stat;

  always #5 clk = ~clk;

  atm_cell_delin uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_byte(in_byte),
    .irq_rd(irq_rd), .hdr_mark(hdr_mark), .stat(stat), .hec_corr(hec_corr),
    .hec_uncorr(hec_uncorr), .irq_stat(irq_stat), .irq_n(irq_n)
  );

  int n_chk = 0;
  int n_bad = 0;
  int marks = 0;
  int gap_ctr = 0;
  bit done = 1'b0;

  always @(negedge clk) if (hdr_mark === 1'b1) marks++;

  // Per-cell vector: [9:8] header damage, [7:6] state code, [5] LCD,
  // [4:1] interrupt status, [0] host read after the check.
  // damage: 0 none, 1 byte0 bit0, 2 HEC bit3, 3 byte0 bits 1:0
  localparam logic [9:0] VEC [34] = '{
    {2'd0, 2'b01, 1'b1, 4'b0000, 1'b0},  // c0  R2 lock
    {2'd0, 2'b01, 1'b1, 4'b0000, 1'b0},
    {2'd0, 2'b01, 1'b1, 4'b0000, 1'b0},
    {2'd0, 2'b01, 1'b1, 4'b0000, 1'b0},
    {2'd0, 2'b01, 1'b1, 4'b0000, 1'b0},
    {2'd0, 2'b01, 1'b1, 4'b0000, 1'b0},  // c5  R5 fifth of DELTA
    {2'd0, 2'b00, 1'b0, 4'b0010, 1'b1},  // c6  R5 R9 sync
    {2'd1, 2'b00, 1'b0, 4'b1000, 1'b1},  // c7  R7 correctable
    {2'd1, 2'b00, 1'b0, 4'b0100, 1'b1},  // c8  R7 second single -> uncorr
    {2'd0, 2'b00, 1'b0, 4'b0000, 1'b0},  // c9
    {2'd2, 2'b00, 1'b0, 4'b1000, 1'b1},  // c10 R7 HEC byte bit
    {2'd3, 2'b00, 1'b0, 4'b0100, 1'b0},
    {2'd3, 2'b00, 1'b0, 4'b0100, 1'b0},
    {2'd3, 2'b00, 1'b0, 4'b0100, 1'b0},
    {2'd3, 2'b00, 1'b0, 4'b0100, 1'b0},
    {2'd3, 2'b00, 1'b0, 4'b0100, 1'b0},
    {2'd3, 2'b10, 1'b1, 4'b0101, 1'b1},  // c16 R6 ALPHA-th error, R9 declare
    {2'd0, 2'b01, 1'b1, 4'b0000, 1'b0},  // c17 R2 relock
    {2'd0, 2'b01, 1'b1, 4'b0000, 1'b0},
    {2'd1, 2'b10, 1'b1, 4'b0000, 1'b0},  // c19 R4 bad in presync
    {2'd0, 2'b01, 1'b1, 4'b0000, 1'b0},
    {2'd0, 2'b01, 1'b1, 4'b0000, 1'b0},
    {2'd0, 2'b01, 1'b1, 4'b0000, 1'b0},
    {2'd0, 2'b01, 1'b1, 4'b0000, 1'b0},
    {2'd0, 2'b01, 1'b1, 4'b0000, 1'b0},
    {2'd0, 2'b01, 1'b1, 4'b0000, 1'b0},
    {2'd0, 2'b00, 1'b0, 4'b0010, 1'b1},  // c26 R5 sync again
    {2'd3, 2'b00, 1'b0, 4'b0100, 1'b0},
    {2'd3, 2'b00, 1'b0, 4'b0100, 1'b0},
    {2'd3, 2'b00, 1'b0, 4'b0100, 1'b0},
    {2'd3, 2'b00, 1'b0, 4'b0100, 1'b0},
    {2'd3, 2'b00, 1'b0, 4'b0100, 1'b0},
    {2'd3, 2'b00, 1'b0, 4'b0100, 1'b1},  // c32 R6 ALPHA-1 errors
    {2'd0, 2'b00, 1'b0, 4'b0000, 1'b0}   // c33 R6 still in sync
  };

  // Long division of {hdr, 8'h00} by 0x107, then the 0x55 offset
  function automatic logic [7:0] ref_hec(input logic [31:0] h);
    logic [39:0] r;
    r = {h, 8'h00};
    for (int i = 39; i >= 8; i--)
      if (r[i]) r[i -: 9] = r[i -: 9] ^ 9'h107;
    return r[7:0] ^ 8'h55;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
  endtask

  // One accepted byte; every fifth one is preceded by an idle junk cycle (R3)
  task automatic put(input logic [7:0] b);
    gap_ctr++;
    if (gap_ctr % 5 == 0) begin
      @(negedge clk);
      in_valid = 1'b0;
      in_byte  = 8'hA5;
    end
    @(negedge clk);
    in_valid = 1'b1;
    in_byte  = b;
  endtask

  task automatic idle(input int n, input logic [7:0] b);
    repeat (n) begin
      @(negedge clk);
      in_valid = 1'b0;
      in_byte  = b;
    end
  endtask

  task automatic send_cell(input int c, input logic [9:0] v);
    logic [7:0] hdr [5];
    int m0;
    hdr[0] = 8'h00; hdr[1] = 8'h00; hdr[2] = 8'h00; hdr[3] = 8'h00;
    hdr[4] = ref_hec(32'h0);
    case (v[9:8])
      2'd1: hdr[0] = hdr[0] ^ 8'h01;
      2'd2: hdr[4] = hdr[4] ^ 8'h08;
      2'd3: hdr[0] = hdr[0] ^ 8'h03;
      default: ;
    endcase
    m0 = marks;
    for (int i = 0; i < 53; i++) begin
      put(i < 5 ? hdr[i] : 8'h00);
      if (i == 12) begin
        chk($sformatf("R8 stat cell %0d (R2 R4 R5 R6)", c), 32'(stat), 32'(v[7:5]));
        chk($sformatf("R9 R7 irq_stat cell %0d", c), 32'(irq_stat), 32'(v[4:1]));
        chk($sformatf("R10 irq_n cell %0d", c), 32'(irq_n), 32'(v[4:1] == 4'b0000));
      end
      if (i == 20 && v[0]) irq_rd = 1'b1;
      if (i == 21) irq_rd = 1'b0;
      if (i == 30 && v[0]) begin
        chk($sformatf("R10 cleared cell %0d", c), 32'(irq_stat), 32'h0);
        chk($sformatf("R10 irq_n released cell %0d", c), 32'(irq_n), 32'h1);
      end
    end
    chk($sformatf("R3 hdr_mark count cell %0d", c), 32'(marks - m0), 32'h1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog R3 act=%0d exp=%0d", 0, 1);
      summary();
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; irq_rd = 1'b0; in_byte = 8'h00;
    repeat (3) @(negedge clk);
    chk("R1 stat in reset", 32'(stat), 32'h5);
    chk("R1 irq_stat in reset", 32'(irq_stat), 32'h0);
    chk("R1 irq_n in reset", 32'(irq_n), 32'h1);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 stat after reset", 32'(stat), 32'h5);

    for (int c = 0; c < 34; c++) send_cell(c, VEC[c]);
    idle(4, 8'h00);

    // Directed: reset during sync
    rst_n = 1'b0;
    @(negedge clk);
    chk("R1 stat on mid-run reset", 32'(stat), 32'h5);
    chk("R1 irq_n on mid-run reset", 32'(irq_n), 32'h1);
    rst_n = 1'b1;

    // R2: lone 0x55 over a cleared window must not lock
    put(8'h55);
    idle(3, 8'h00);
    chk("R2 no lock before window fill", 32'(stat), 32'h5);
    put(8'h00); put(8'h00); put(8'h00); put(8'h00);
    // R3: a would-be HEC byte with the strobe low is ignored
    idle(3, 8'h55);
    chk("R3 strobe-low byte ignored", 32'(stat), 32'h5);
    put(8'h55);
    idle(3, 8'h00);
    chk("R2 lock on first valid window", 32'(stat), 32'h3);

    done = 1'b1;
    summary();
    $finish;
  end

endmodule